// File: doc/BRIEF.md
# Stochastic Dense Layer with Leaky Integrate-and-Fire Outputs

This block evaluates one fully connected neural layer with stochastic arithmetic. Each input value is turned into a pseudo-random bitstream whose density of ones follows its magnitude. Each synapse has its own weight bitstream generator. The product of an input and a weight is a single AND of the two stream bits. Every cycle, each neuron adds up the signed synapse bits into a running dot-product total. The same per-cycle sum also drives a leaky integrate-and-fire membrane, and the neuron counts the spikes that membrane produces.

Weights are fixed at elaboration time as signed Q8.8 constants and become logic constants, so no memory is involved. A single-cycle start strobe latches the input vector, reseeds every generator and clears all neuron state. The block then runs for exactly `STREAM_LEN` cycles, raises `done` for one cycle and holds its results until the next start. The per-neuron totals and spike counts are then read as class scores.

Top module: `sc_dense_lif_layer`

## Requirements
- R1: Every stream generator is a 16-bit shift register that moves left, taking as its new bit 0 the XOR of state bits 15, 13, 12 and 10. Input k is seeded with 0xACE1 + 7·k. The synapse for neuron n and input k is seeded with 0xBEEF + 13·(n·N_IN + k), modulo 2^16, and a zero seed becomes 0x0001. A stream bit is taken from the current state, before that cycle's shift. Input streams use a level of 0 for a negative Q8.8 value, 256 for a value of 1.0 or more, and the value's low nine bits otherwise.
- R2: A weight stream uses the absolute value of its Q8.8 weight as its level, with magnitudes of 1.0 or more treated as 256. The weight's sign bit (bit 15) selects whether the synapse adds or subtracts.
- R3: A stream bit is 1 when the level is 256, or when state bits 7:0 are below the level's low eight bits. Each cycle a neuron's signed sum counts +1 for every positive synapse and −1 for every negative synapse whose input bit AND weight bit is 1. The accumulator output is the saturating total of these sums over the run.
- R4: On each run cycle c (counting from 0), the membrane adds the cycle's sum. When c mod 16 = 15, it then subtracts its own value arithmetically shifted right by 4. If the result is at or above `THRESH`, the neuron's spike count increments and the membrane becomes 0.
- R5: A start clears every accumulator, membrane and spike count and reseeds every generator, including when it arrives during a run. The result then matches a fresh run on the new inputs.
- R6: `busy` is high from the edge that takes the start until the edge that completes cycle STREAM_LEN−1. `done` is high for exactly the one cycle after that edge, and never while `busy` is high.
- R7: After a run completes, accumulator and spike count outputs stay unchanged until the next start.
- R8: Synchronous reset, including one applied during a run, leaves `busy` and `done` low and every accumulator and spike count at zero.
- R9: Input values are latched by the start. Changes on `in_vals` during a run have no effect on the results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle run strobe; latches inputs |
| in_vals | input | N_IN*16 | Signed Q8.8 inputs, input k in bits 16k+15:16k |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| acc_flat | output | N_NEU*ACC_W | Signed dot-product totals, neuron n at slice n |
| cnt_flat | output | N_NEU*CNT_W | Spike counts, neuron n at slice n |

## Verification
The run starts at the edge that samples `start`. Cycle c of the run is then completed by edge c+1. So `done` and the final totals and counts are due STREAM_LEN edges after the start edge, and `done` must still be low one edge earlier. The bench drives on falling edges and counts exactly STREAM_LEN−1 falling edges after the start edge to sample the "not yet" state. It samples once more for the finished state, then several more times to confirm the results hold. Expected totals and counts come from an arithmetic model of the generators, synapses and membranes run over the same number of cycles.

// File: rtl/sc_dense_pkg.sv
package sc_dense_pkg;

  localparam int WORD_W  = 16;
  localparam int LEVEL_W = 9;

  // one step of the 16-bit Fibonacci generator
  function automatic logic [15:0] lfsr_step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [LEVEL_W-1:0] level_from_mag(input logic [15:0] m);
    return (m >= 16'd256) ? 9'd256 : m[8:0];
  endfunction

  function automatic logic [LEVEL_W-1:0] input_level(input logic [15:0] v);
    return v[15] ? '0 : level_from_mag(v);
  endfunction

  function automatic logic [15:0] magnitude(input logic [15:0] w);
    return w[15] ? (~w + 16'd1) : w;
  endfunction

  function automatic logic [15:0] fix_seed(input logic [15:0] s);
    return (s == 16'd0) ? 16'h0001 : s;
  endfunction

  function automatic logic [15:0] input_seed(input int k);
    return fix_seed(16'(32'hACE1 + k * 7));
  endfunction

  function automatic logic [15:0] weight_seed(input int n, input int k, input int n_in);
    return fix_seed(16'(32'hBEEF + n * n_in * 13 + k * 13));
  endfunction

endpackage

// File: rtl/sc_stream_gen.sv
module sc_stream_gen #(
  parameter logic [15:0] SEED = 16'h0001
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic       step,
  input  logic [8:0] level,
  output logic       bit_o
);
  import sc_dense_pkg::*;

  logic [15:0] state;

  always_ff @(posedge clk) begin
    if (rst || load) state <= SEED;
    else if (step)   state <= lfsr_step(state);
  end

  assign bit_o = level[8] | (state[7:0] < level[7:0]);

endmodule

// File: rtl/sc_lif_neuron.sv
module sc_lif_neuron #(
  parameter int N_IN       = 16,
  parameter int ACC_W      = 16,
  parameter int CNT_W      = 11,
  parameter int THRESH     = 64,
  parameter int LEAK_SHIFT = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    en,
  input  logic                    leak,
  input  logic [N_IN-1:0]         syn_bits,
  input  logic [N_IN-1:0]         neg_bits,
  output logic signed [ACC_W-1:0] acc_o,
  output logic [CNT_W-1:0]        cnt_o
);
  localparam logic signed [ACC_W-1:0] TH      = ACC_W'(THRESH);
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W-1:0] sum;
  logic signed [ACC_W:0]   acc_wide;
  logic signed [ACC_W-1:0] acc_next;
  logic signed [ACC_W-1:0] mem, mem_add, mem_leak;
  logic                    fire;

  always_comb begin
    sum = '0;
    for (int k = 0; k < N_IN; k++) begin
      if (syn_bits[k]) sum = neg_bits[k] ? sum - 1'b1 : sum + 1'b1;
    end
  end

  always_comb begin
    acc_wide = {acc_o[ACC_W-1], acc_o} + {sum[ACC_W-1], sum};
    if (acc_wide[ACC_W] != acc_wide[ACC_W-1])
      acc_next = acc_wide[ACC_W] ? ACC_MIN : ACC_MAX;
    else
      acc_next = acc_wide[ACC_W-1:0];
  end

  always_comb begin
    mem_add  = mem + sum;
    mem_leak = leak ? (mem_add - (mem_add >>> LEAK_SHIFT)) : mem_add;
    fire     = (mem_leak >= TH);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc_o <= '0;
      mem   <= '0;
      cnt_o <= '0;
    end else if (en) begin
      acc_o <= acc_next;
      mem   <= fire ? '0 : mem_leak;
      if (fire && !(&cnt_o)) cnt_o <= cnt_o + 1'b1;
    end
  end

endmodule

// File: rtl/sc_dense_lif_layer.sv
module sc_dense_lif_layer #(
  parameter int N_IN       = 16,
  parameter int N_NEU      = 10,
  parameter int STREAM_LEN = 1024,
  parameter int THRESH     = 64,
  parameter int LEAK_LOG   = 4,
  parameter int LEAK_SHIFT = 4,
  parameter logic [N_NEU*N_IN*16-1:0] WEIGHTS = {(N_NEU*N_IN){16'h0040}},
  localparam int ACC_W = $clog2(N_IN*STREAM_LEN+1) + 2,
  localparam int CNT_W = $clog2(STREAM_LEN+1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [N_IN*16-1:0]     in_vals,
  output logic                   busy,
  output logic                   done,
  output logic [N_NEU*ACC_W-1:0] acc_flat,
  output logic [N_NEU*CNT_W-1:0] cnt_flat
);
  import sc_dense_pkg::*;

  localparam int CYC_W = (STREAM_LEN > 2) ? $clog2(STREAM_LEN) : 1;
  localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(STREAM_LEN - 1);

  logic [N_IN*16-1:0] in_lat;
  logic [CYC_W-1:0]   cyc;
  logic               leak;
  logic [N_IN-1:0]    x_bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      cyc    <= '0;
      in_lat <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy   <= 1'b1;
        cyc    <= '0;
        in_lat <= in_vals;
      end else if (busy) begin
        cyc <= cyc + 1'b1;
        if (cyc == LAST_CYC) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign leak = &cyc[LEAK_LOG-1:0];

  for (genvar k = 0; k < N_IN; k++) begin : g_in
    sc_stream_gen #(.SEED(input_seed(k))) u_gen (
      .clk   (clk),
      .rst   (rst),
      .load  (start),
      .step  (busy),
      .level (input_level(in_lat[k*16 +: 16])),
      .bit_o (x_bits[k])
    );
  end

  for (genvar n = 0; n < N_NEU; n++) begin : g_neu
    logic [N_IN-1:0]         w_bits;
    logic [N_IN-1:0]         neg_bits;
    logic signed [ACC_W-1:0] acc_n;
    logic [CNT_W-1:0]        cnt_n;

    for (genvar k = 0; k < N_IN; k++) begin : g_syn
      localparam logic [15:0] W = WEIGHTS[(n*N_IN+k)*16 +: 16];
      assign neg_bits[k] = W[15];
      sc_stream_gen #(.SEED(weight_seed(n, k, N_IN))) u_wgen (
        .clk   (clk),
        .rst   (rst),
        .load  (start),
        .step  (busy),
        .level (level_from_mag(magnitude(W))),
        .bit_o (w_bits[k])
      );
    end

    sc_lif_neuron #(
      .N_IN(N_IN), .ACC_W(ACC_W), .CNT_W(CNT_W),
      .THRESH(THRESH), .LEAK_SHIFT(LEAK_SHIFT)
    ) u_neu (
      .clk      (clk),
      .rst      (rst),
      .clear    (start),
      .en       (busy),
      .leak     (leak),
      .syn_bits (x_bits & w_bits),
      .neg_bits (neg_bits),
      .acc_o    (acc_n),
      .cnt_o    (cnt_n)
    );

    assign acc_flat[n*ACC_W +: ACC_W] = acc_n;
    assign cnt_flat[n*CNT_W +: CNT_W] = cnt_n;
  end

endmodule

// File: rtl/sc_dense_lif_layer_chk.sv
module sc_dense_lif_layer_chk #(
  parameter int ACC_FW = 8,
  parameter int CNT_FW = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [ACC_FW-1:0] acc_flat,
  input logic [CNT_FW-1:0] cnt_flat
);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6
  done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R5
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (busy && cnt_flat == '0 && acc_flat == '0));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(acc_flat) && $stable(cnt_flat)));

  // R4
  cnt_mono_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !start) |=> (cnt_flat[CNT_W-1:0] >= $past(cnt_flat[CNT_W-1:0])));

endmodule

bind sc_dense_lif_layer sc_dense_lif_layer_chk #(
  .ACC_FW(N_NEU*ACC_W), .CNT_FW(N_NEU*CNT_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .acc_flat(acc_flat), .cnt_flat(cnt_flat)
);

// File: tb/tb_sc_dense_lif_layer.sv
module tb_sc_dense_lif_layer;
  localparam int N_IN  = 3;
  localparam int N_NEU = 4;
  localparam int L     = 64;
  localparam int TH    = 10;
  localparam int ACC_W = $clog2(N_IN*L+1) + 2;
  localparam int CNT_W = $clog2(L+1);
  // neuron n, input k at bits (n*N_IN+k)*16
  localparam logic [N_NEU*N_IN*16-1:0] WV = {
    16'hFFC0, 16'h0040, 16'h0080,   // n3
    16'hFF00, 16'h0100, 16'h0100,   // n2
    16'hFF00, 16'hFF00, 16'hFF00,   // n1
    16'h0100, 16'h0100, 16'h0100    // n0
  };

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [N_IN*16-1:0] in_vals;
  logic busy, done;
  logic [N_NEU*ACC_W-1:0] acc_flat;
  logic [N_NEU*CNT_W-1:0] cnt_flat;

  logic [15:0] cur_in [N_IN];
  int exp_acc [N_NEU];
  int exp_cnt [N_NEU];
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  always_comb
    for (int k = 0; k < N_IN; k++) in_vals[k*16 +: 16] = cur_in[k];

  sc_dense_lif_layer #(
    .N_IN(N_IN), .N_NEU(N_NEU), .STREAM_LEN(L), .THRESH(TH),
    .LEAK_LOG(4), .LEAK_SHIFT(4), .WEIGHTS(WV)
  ) dut (
    .clk(clk), .rst(rst), .start(start), .in_vals(in_vals),
    .busy(busy), .done(done), .acc_flat(acc_flat), .cnt_flat(cnt_flat)
  );

  function automatic logic [15:0] nxt(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic int lvl_mag(input logic [15:0] m);
    return (m >= 16'd256) ? 256 : int'(m);
  endfunction

  function automatic bit sbit(input logic [15:0] s, input int lv);
    return (lv == 256) || (int'(s[7:0]) < lv);
  endfunction

  function automatic logic [15:0] sd(input int v);
    logic [15:0] r = 16'(v);
    return (r == 0) ? 16'h0001 : r;
  endfunction

  task automatic check(input string req, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // arithmetic model of a full run on a given input vector
  task automatic model(input logic [15:0] v [N_IN]);
    logic [15:0] xs [N_IN];
    logic [15:0] ws [N_NEU][N_IN];
    int mem [N_NEU];
    for (int k = 0; k < N_IN; k++) xs[k] = sd(32'hACE1 + 7*k);
    for (int n = 0; n < N_NEU; n++) begin
      exp_acc[n] = 0; exp_cnt[n] = 0; mem[n] = 0;
      for (int k = 0; k < N_IN; k++) ws[n][k] = sd(32'hBEEF + 13*(n*N_IN+k));
    end
    for (int c = 0; c < L; c++) begin
      for (int n = 0; n < N_NEU; n++) begin
        int s = 0;
        for (int k = 0; k < N_IN; k++) begin
          logic [15:0] w = WV[(n*N_IN+k)*16 +: 16];
          logic [15:0] wm = w[15] ? (~w + 16'd1) : w;
          int xl = v[k][15] ? 0 : lvl_mag(v[k]);
          if (sbit(xs[k], xl) && sbit(ws[n][k], lvl_mag(wm)))
            s += w[15] ? -1 : 1;
        end
        exp_acc[n] += s;
        mem[n] += s;
        if ((c % 16) == 15) mem[n] = mem[n] - (mem[n] >>> 4);
        if (mem[n] >= TH) begin mem[n] = 0; exp_cnt[n]++; end
      end
      for (int k = 0; k < N_IN; k++) xs[k] = nxt(xs[k]);
      for (int n = 0; n < N_NEU; n++)
        for (int k = 0; k < N_IN; k++) ws[n][k] = nxt(ws[n][k]);
    end
  endtask

  task automatic check_results(input string tag);
    for (int n = 0; n < N_NEU; n++) begin
      check("R3", {tag, " acc"}, int'($signed(acc_flat[n*ACC_W +: ACC_W])), exp_acc[n]);
      check("R4", {tag, " spikes"}, int'(cnt_flat[n*CNT_W +: CNT_W]), exp_cnt[n]);
    end
  endtask

  // mode 0 plain, 1 restart mid-run (R5), 2 inputs change during run (R9)
  task automatic run_case(input string tag, input logic [15:0] a0, input logic [15:0] a1,
                          input logic [15:0] a2, input int mode);
    logic [15:0] v [N_IN];
    v[0] = a0; v[1] = a1; v[2] = a2;
    model(v);
    if (mode == 1) begin
      cur_in[0] = 16'h0100; cur_in[1] = 16'h0100; cur_in[2] = 16'h0100;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      repeat (10) @(negedge clk);
    end
    cur_in = v;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (mode == 2) begin
      cur_in[0] = 16'h0100; cur_in[1] = 16'h0000; cur_in[2] = 16'h00F0;
    end
    repeat (L-1) @(negedge clk);
    check("R6", {tag, " done early"}, int'(done), 0);
    check("R6", {tag, " busy before end"}, int'(busy), 1);
    @(negedge clk);
    check("R6", {tag, " done"}, int'(done), 1);
    check("R6", {tag, " busy at end"}, int'(busy), 0);
    check_results(tag);
    @(negedge clk);
    check("R6", {tag, " done single"}, int'(done), 0);
    repeat (4) @(negedge clk);
    check_results({tag, " R7 hold"});
  endtask

  initial begin
    for (int c = 0; c < 100000 && !finished; c++) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < N_IN; k++) cur_in[k] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    check("R8", "busy", int'(busy), 0);
    check("R8", "done", int'(done), 0);
    check("R8", "acc", int'(acc_flat != '0), 0);
    check("R8", "cnt", int'(cnt_flat != '0), 0);

    run_case("zero inputs R3", 16'h0000, 16'h0000, 16'h0000, 0);
    run_case("full inputs R2", 16'h0100, 16'h0100, 16'h0100, 0);
    run_case("fractions R1", 16'h0100, 16'h0080, 16'h0040, 0);
    run_case("clamps R1", 16'h7FFF, 16'h8000, 16'h00C0, 0);
    run_case("odd levels R1", 16'h00C0, 16'h0033, 16'h0001, 0);
    run_case("restart R5", 16'h0080, 16'h00E0, 16'h0100, 1);
    run_case("latched R9", 16'h0020, 16'h0100, 16'h0000, 2);

    // R8 reset during a run
    cur_in[0] = 16'h0100; cur_in[1] = 16'h0100; cur_in[2] = 16'h0100;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    check("R8", "busy after mid reset", int'(busy), 0);
    check("R8", "acc after mid reset", int'(acc_flat != '0), 0);
    check("R8", "cnt after mid reset", int'(cnt_flat != '0), 0);
    repeat (L+4) @(negedge clk);
    check("R8", "no done after reset", int'(done), 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule